// File: doc/BRIEF.md
# Three-Stage 1:16 Serial-to-Parallel Deserializer

This block turns a recovered serial bit stream into 16-bit parallel words. It sits right after clock and data recovery and runs entirely on the recovered bit clock. Each incoming bit goes into a shift register. Once sixteen bits have arrived, the shift register contents are copied into a holding register. An output register then takes the holding register contents on the falling edge of a parallel clock that the block makes by dividing the bit clock by sixteen. The output register drives the parallel bus.

A framer placed downstream finds the word alignment in the serial stream. It signals that alignment through a synchronous word-boundary restart input. The restart input drops any word that is half assembled and starts counting a new word from the next bit. A word that is already in the holding register when the restart arrives is not lost: it still goes out on the next falling edge of the parallel clock.

Top module: `deser16_pipe`

## Requirements
- R1: While `rst` is high at a rising edge of `clk_bit`, `pdata_out` is cleared to zero and `pclk_out` is driven low.
- R2: Bits are packed most significant bit first. The bit sampled at the first `clk_bit` edge of a word lands on `pdata_out[15]`, and the sixteenth bit lands on `pdata_out[0]`.
- R3: `pdata_out` changes only at a `clk_bit` edge where `pclk_out` falls. Without a restart, a word whose first bit is sampled at edge e appears at edge e+24.
- R4: Without a restart, `pclk_out` has a period of 16 bit clocks and stays high for 8 of them. It rises at the edge where the holding register loads.
- R5: Each complete word is delivered once, in arrival order. No word overwrites a holding register value that has not yet been delivered.
- R6: When `word_realign` is high at an edge, the bit count restarts. The bit sampled at the next edge becomes bit 15 of a new word, and the partial word is discarded.
- R7: If a word is already held when `word_realign` is asserted, it still appears on `pdata_out` at the next falling edge of `pclk_out`, which comes 9 edges after the restart.
- R8: After reset, `pdata_out` stays zero until the first complete word has passed through all three stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Recovered serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data, sampled on the rising edge of `clk_bit` |
| word_realign | input | 1 | Synchronous word-boundary restart from the framer |
| pclk_out | output | 1 | Parallel clock, bit clock divided by 16 |
| pdata_out | output | 16 | Parallel data word, most significant bit first |

## Verification
The embedded checks assume that `word_realign` is a one-cycle pulse. They also assume that a restart does not repeat so often that the count can never pass mid-word, because the no-overwrite property relies on the mid-word transfer happening between two holding-register loads. The stimulus drives every input at the falling edge of the bit clock. It sends a restart as a single pulse, always after at least a few stray bits and at most seven, which places each restart before the output transfer of the word already held. Apart from that, the serial stream runs continuously: whole words are sent back to back, and idle zero words pad the end.

// File: rtl/deser16_pkg.sv
package deser16_pkg;

  // Timing controls produced by the word phase counter
  typedef struct packed {
    logic hold_ld;   // one-cycle strobe: copy shift register into holding stage
    logic mid_tick;  // count is at mid-word: output transfer point
    logic pclk;      // registered parallel clock
  } phase_t;

endpackage

// File: rtl/deser16_phase.sv
module deser16_phase #(
  parameter int WORD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 realign,
  output deser16_pkg::phase_t  ph
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] MID_C  = CNT_W'(WORD_W / 2);
  localparam logic [CNT_W-1:0] ZERO_C = '0;

  logic [CNT_W-1:0] cnt;
  logic             hold_ld_q;
  logic             pclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      hold_ld_q <= 1'b0;
      pclk_q    <= 1'b0;
    end else begin
      if (realign || cnt == LAST_C) cnt <= '0;
      else                          cnt <= cnt + 1'b1;
      hold_ld_q <= (cnt == LAST_C);
      if (cnt == ZERO_C)     pclk_q <= 1'b1;
      else if (cnt == MID_C) pclk_q <= 1'b0;
    end
  end

  assign ph.hold_ld  = hold_ld_q;
  assign ph.mid_tick = (cnt == MID_C);
  assign ph.pclk     = pclk_q;

  // R6
  realign_restart_chk: assert property (@(posedge clk) disable iff (rst)
    realign |=> (cnt == ZERO_C));

  // R4
  word_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST_C && !realign) |=> (cnt == ZERO_C && hold_ld_q));

endmodule

// File: rtl/deser16_sipo.sv
module deser16_sipo #(
  parameter int WORD_W    = 16,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  output logic [WORD_W-1:0] sr
);
  generate
    if (MSB_FIRST) begin : g_msb
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[WORD_W-2:0], din};
      end
    end else begin : g_lsb
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {din, sr[WORD_W-1:1]};
      end
    end
  endgenerate

endmodule

// File: rtl/deser16_hold.sv
module deser16_hold #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              take,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q,
  output logic              pending
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= '0;
      pending <= 1'b0;
    end else begin
      if (ld) q <= d;
      if (ld)        pending <= 1'b1;
      else if (take) pending <= 1'b0;
    end
  end

  // R5
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    ld |-> !pending);

endmodule

// File: rtl/deser16_outreg.sv
module deser16_outreg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end

endmodule

// File: rtl/deser16_pipe.sv
module deser16_pipe #(
  parameter int WORD_W    = 16,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic              clk_bit,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              word_realign,
  output logic              pclk_out,
  output logic [WORD_W-1:0] pdata_out
);
  deser16_pkg::phase_t ph;
  logic [WORD_W-1:0]   shreg;
  logic [WORD_W-1:0]   holdreg;
  logic                hold_pending;
  logic                out_ld;

  deser16_phase #(.WORD_W(WORD_W)) u_phase (
    .clk     (clk_bit),
    .rst     (rst),
    .realign (word_realign),
    .ph      (ph)
  );

  deser16_sipo #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_sipo (
    .clk (clk_bit),
    .rst (rst),
    .din (ser_in),
    .sr  (shreg)
  );

  assign out_ld = ph.mid_tick && hold_pending;

  deser16_hold #(.WORD_W(WORD_W)) u_hold (
    .clk     (clk_bit),
    .rst     (rst),
    .ld      (ph.hold_ld),
    .take    (out_ld),
    .d       (shreg),
    .q       (holdreg),
    .pending (hold_pending)
  );

  deser16_outreg #(.WORD_W(WORD_W)) u_out (
    .clk (clk_bit),
    .rst (rst),
    .ld  (out_ld),
    .d   (holdreg),
    .q   (pdata_out)
  );

  assign pclk_out = ph.pclk;

  // R3
  data_on_fall_chk: assert property (@(posedge clk_bit) disable iff (rst)
    !$stable(pdata_out) |-> $fell(pclk_out));

  // R4
  pclk_rise_on_load_chk: assert property (@(posedge clk_bit) disable iff (rst)
    ph.hold_ld |=> pclk_out);

  // R7
  pending_survives_chk: assert property (@(posedge clk_bit) disable iff (rst)
    (hold_pending && !out_ld && !ph.hold_ld) |=> (hold_pending && $stable(holdreg)));

endmodule

// File: tb/deser16_pipe_test.sv
module deser16_pipe_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] d;
    int           due;
    bit           after_restart;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ser_in = 1'b0;
  logic         realign = 1'b0;
  logic         pclk;
  logic [W-1:0] pdata;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t q[$];

  deser16_pipe #(.WORD_W(W)) uut (
    .clk_bit      (clk),
    .rst          (rst),
    .ser_in       (ser_in),
    .word_realign (realign),
    .pclk_out     (pclk),
    .pdata_out    (pdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // drive one word MSB first; caller sits at a falling clock edge
  task automatic send_word(input logic [W-1:0] v, input int extra);
    int e0;
    e0 = cyc + 1;
    for (int i = 0; i < W; i++) begin
      ser_in  = v[W-1-i];
      realign = 1'b0;
      @(negedge clk);
    end
    q.push_back('{v, e0 + 24 + extra, extra > 0});
  endtask

  task automatic stray_bits_restart(input int n);
    for (int i = 0; i < n; i++) begin
      ser_in = i[0];
      @(negedge clk);
    end
    ser_in  = 1'b1;
    realign = 1'b1;
    @(negedge clk);
    realign = 1'b0;
  endtask

  // monitor: samples a quarter period after each rising edge
  initial begin
    logic         prev_p;
    logic [W-1:0] prev_d;
    logic [W-1:0] last_d;
    int           last_fall;
    int           last_rise;
    bit           restart_seen;
    exp_t         e;
    prev_p = 1'b0; prev_d = '0; last_d = '0;
    last_fall = -1; last_rise = -1; restart_seen = 1'b0;
    @(negedge rst);
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (done) break;
      if (!prev_p && pclk) last_rise = cyc;
      if (prev_p && !pclk) begin
        if (!restart_seen) begin
          // R4 high time and period
          if (last_rise >= 0) chk(cyc - last_rise == 8, "R4 high time", cyc - last_rise, 8);
          if (last_fall >= 0) chk(cyc - last_fall == 16, "R4 period", cyc - last_fall, 16);
        end
        if (q.size() > 0) begin
          e = q.pop_front();
          // R2 R5 word content and order
          chk(pdata === e.d, "R2/R5 word", int'(pdata), int'(e.d));
          if (e.after_restart)
            chk(cyc == e.due, "R7 held word timing", cyc, e.due);
          else
            chk(cyc == e.due, "R3 latency", cyc, e.due);
          last_d = e.d;
        end else begin
          // R8 R5 nothing new: bus keeps zero or last word
          chk(pdata === last_d, "R8/R5 no new word", int'(pdata), int'(last_d));
        end
        last_fall = cyc;
        restart_seen = 1'b0;
      end else if (pdata !== prev_d) begin
        chk(1'b0, "R3 change off fall", int'(pdata), int'(prev_d));
      end
      if (realign) restart_seen = 1'b1;
      prev_p = pclk;
      prev_d = pdata;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(pdata === '0, "R1 data", int'(pdata), 0);
    chk(pclk === 1'b0, "R1 pclk", int'(pclk), 0);
    rst = 1'b0;
    send_word(16'h8000, 0);   // R2 single first bit lands on bit 15
    send_word(16'h0001, 0);
    send_word(16'hA5C3, 0);
    send_word(16'hFFFF, 0);
    send_word(16'h0000, 0);
    send_word(16'h1234, 0);
    send_word(16'h5A5A, 6);   // R7 held while restart follows 5 stray bits
    stray_bits_restart(5);    // R6 partial word discarded
    send_word(16'hBEEF, 3);   // R6 realigned word; R7 held across next restart
    stray_bits_restart(2);
    send_word(16'h3C3C, 0);
    send_word(16'hCAFE, 0);
    send_word(16'h0000, 0);
    send_word(16'h0000, 0);
    ser_in = 1'b0;
    repeat (40) @(negedge clk);
    // R5 every sent word delivered
    chk(q.size() == 0, "R5 all delivered", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule